// File: doc/BRIEF.md
# RAM Bank Size Probe

This block sizes two RAM banks after power-up without walking every address. It programs a 4-bit memory configuration register to the largest setting (2 Mbyte for both banks). Then, for each bank in turn, it writes a test pattern into the lowest 512-byte window and reads higher windows back. While the configuration is at its largest, a smaller bank wraps its address space. A 128 Kbyte bank repeats every 512 bytes and a 512 Kbyte bank repeats every 1 Kbyte. The first window that returns the whole pattern therefore gives the bank size. When both banks are resolved, the block loads the final configuration and reports the total RAM size.

A one-cycle `start` pulse launches the probe. The block talks to memory through a 16-bit word port.
- The request channel is valid/ready. Once `mem_req_valid` is raised, address, write flag and write data stay unchanged until `mem_req_ready` is seen high on a clock edge.
- The read-response channel has no back-pressure. The block keeps at most one read outstanding and does not request again until `mem_rvalid` returns.

The results are `done`, `error`, `bank1_absent`, the configuration value and the total size in Kbyte. All of them hold until the next start.

Top module: `ram_size_probe`

## Requirements
- R1: After reset, `mem_cfg` is 0, `total_kb` is 0, `done`, `error` and `bank1_absent` are 0, and no memory request is raised.
- R2: A start pulse sets `mem_cfg` to 4'hA before the first memory request. `mem_cfg` keeps that value for every request of the probe, and `done` is low while the probe runs.
- R3: For each probed bank, the block writes 256 words. Word i goes to byte address base + 2*i and carries PATTERN ^ i. The base is 0x000000 for bank 0 and 0x200000 for bank 1.
- R4: After the write, compares run in a fixed order, at window offsets 0x200, 0x400 and 0x000 from the base. The first full match gives the size code: 00 = 128 Kbyte, 01 = 512 Kbyte, 10 = 2 Mbyte. In `mem_cfg`, bank 0's code sits in bits [3:2] and bank 1's in bits [1:0]. Code 11 never appears.
- R5: A request held without ready keeps address, write flag and data stable. After a read is accepted, no new request is raised until its response arrives.
- R6: A compare counts as a match only when all 256 words equal the pattern. The first mismatching word ends that compare at once, and the next one begins.
- R7: If bank 0 fails all three compares, `error` and `done` go high, `mem_cfg` stays 4'hA, `total_kb` is 0, and bank 1 is never accessed.
- R8: If bank 1 fails all three compares, `bank1_absent` goes high, its field is written as 00, and `error` stays low.
- R9: `total_kb` equals the size of bank 0 plus the size of bank 1, where an absent bank 1 counts as zero.
- R10: A start pulse during a probe is ignored. The result and the number of accesses are those of an undisturbed probe.
- R11: `done` and the results hold with no memory traffic until the next start, which clears `done` and `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches a probe |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this edge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the word access |
| mem_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 16 | Read response data |
| done | output | 1 | Probe finished (with or without error) |
| error | output | 1 | Bank 0 failed every compare |
| bank1_absent | output | 1 | Bank 1 failed every compare |
| mem_cfg | output | 4 | Memory configuration register value |
| total_kb | output | 13 | Total RAM size in Kbyte |

## Verification
The assertions check the handshake rules on every cycle. These are request stability under back-pressure and the single outstanding read. They also check the results against each other: the probe value of the configuration during traffic, that the size codes are legal, that the absent field is zero, that an error comes with the probe value and a zero total, and that `done` holds. The size decision itself can only be shown by the bench scenarios, because it depends on how memory aliases. These scenarios use an aliasing memory model with each size, an absent bank, a dead bank 0, a corrupted word that cuts a compare short, and a stray start pulse. The bench checks the final register, the total, and the exact read and write counts that follow from early termination.

// File: rtl/ram_probe_pkg.sv
package ram_probe_pkg;

  localparam int TOTAL_W = 13;
  localparam logic [3:0] CFG_PROBE = 4'hA;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RD_REQ,
    ST_RD_WAIT
  } probe_state_e;

  typedef enum logic [1:0] {
    SZ_128K = 2'b00,
    SZ_512K = 2'b01,
    SZ_2M   = 2'b10,
    SZ_RSVD = 2'b11
  } size_code_e;

  function automatic logic [TOTAL_W-1:0] size_kb(input logic [1:0] code);
    case (code)
      SZ_128K: size_kb = TOTAL_W'(128);
      SZ_512K: size_kb = TOTAL_W'(512);
      SZ_2M:   size_kb = TOTAL_W'(2048);
      default: size_kb = '0;
    endcase
  endfunction

endpackage

// File: rtl/probe_word_counter.sv
module probe_word_counter #(
  parameter int WORDS = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (inc) idx <= idx + 1'b1;
  end

  assign last = (idx == IDX_W'(WORDS - 1));

  // a step never runs past its window
  assert_idx_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && inc && !clr) |=> 1'b0);

endmodule

// File: rtl/probe_pattern.sv
module probe_pattern #(
  parameter int DATA_W = 16,
  parameter int IDX_W = 8,
  parameter logic [DATA_W-1:0] PATTERN = 16'hA55A
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pat,
  output logic              match
);

  assign pat   = PATTERN ^ DATA_W'(idx);
  assign match = (rdata == pat);

endmodule

// File: rtl/probe_addr_gen.sv
module probe_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int IDX_W = 8,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 24'h200000,
  localparam int WIN_BYTES = 2 * (1 << IDX_W)
) (
  input  logic              bank,
  input  logic [1:0]        step,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] win_off;

  always_comb begin
    base = bank ? BANK1_BASE : '0;
    case (step)
      2'd1:    win_off = ADDR_W'(WIN_BYTES);
      2'd2:    win_off = ADDR_W'(2 * WIN_BYTES);
      default: win_off = '0;
    endcase
  end

  assign addr = base + win_off + ADDR_W'({idx, 1'b0});

endmodule

// File: rtl/ram_size_probe.sv
module ram_size_probe
  import ram_probe_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int WIN_WORDS = 256,
  parameter logic [DATA_W-1:0] PATTERN = 16'hA55A,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 24'h200000,
  localparam int IDX_W = $clog2(WIN_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_rvalid,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               done,
  output logic               error,
  output logic               bank1_absent,
  output logic [3:0]         mem_cfg,
  output logic [TOTAL_W-1:0] total_kb
);

  probe_state_e      state;
  logic              bank;
  logic [1:0]        step;
  logic [1:0]        b0_code;
  logic [IDX_W-1:0]  idx;
  logic              last;
  logic              idx_clr;
  logic              idx_inc;
  logic              match;
  logic [1:0]        hit_code;

  probe_word_counter #(.WORDS(WIN_WORDS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc),
    .idx(idx), .last(last)
  );

  probe_pattern #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PATTERN(PATTERN)) u_pat (
    .idx(idx), .rdata(mem_rdata), .pat(mem_wdata), .match(match)
  );

  probe_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK1_BASE(BANK1_BASE)) u_addr (
    .bank(bank), .step(step), .idx(idx), .addr(mem_addr)
  );

  assign mem_req_valid = (state == ST_WRITE) || (state == ST_RD_REQ);
  assign mem_we        = (state == ST_WRITE);
  assign hit_code      = step - 2'd1;

  always_comb begin
    idx_clr = 1'b0;
    idx_inc = 1'b0;
    case (state)
      ST_IDLE:    idx_clr = start;
      ST_WRITE:   if (mem_req_ready) begin
                    if (last) idx_clr = 1'b1;
                    else      idx_inc = 1'b1;
                  end
      ST_RD_WAIT: if (mem_rvalid) begin
                    if (!match || last) idx_clr = 1'b1;
                    else                idx_inc = 1'b1;
                  end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bank         <= 1'b0;
      step         <= 2'd0;
      b0_code      <= 2'd0;
      mem_cfg      <= 4'h0;
      done         <= 1'b0;
      error        <= 1'b0;
      bank1_absent <= 1'b0;
      total_kb     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          mem_cfg      <= CFG_PROBE;
          done         <= 1'b0;
          error        <= 1'b0;
          bank1_absent <= 1'b0;
          total_kb     <= '0;
          bank         <= 1'b0;
          step         <= 2'd0;
          state        <= ST_WRITE;
        end
        ST_WRITE: if (mem_req_ready && last) begin
          step  <= 2'd1;
          state <= ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rvalid) begin
          if (match && !last) begin
            state <= ST_RD_REQ;
          end else if (match) begin
            if (!bank) begin
              b0_code <= hit_code;
              bank    <= 1'b1;
              step    <= 2'd0;
              state   <= ST_WRITE;
            end else begin
              mem_cfg  <= {b0_code, hit_code};
              total_kb <= size_kb(b0_code) + size_kb(hit_code);
              done     <= 1'b1;
              state    <= ST_IDLE;
            end
          end else if (step != 2'd3) begin
            step  <= step + 2'd1;
            state <= ST_RD_REQ;
          end else if (!bank) begin
            error <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            mem_cfg      <= {b0_code, 2'b00};
            total_kb     <= size_kb(b0_code);
            bank1_absent <= 1'b1;
            done         <= 1'b1;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_we) |=> !mem_req_valid);

  assert_cfg_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_cfg == CFG_PROBE && !done));

  assert_codes_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (mem_cfg[3:2] != 2'b11 && mem_cfg[1:0] != 2'b11));

  assert_error_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (done && mem_cfg == CFG_PROBE && total_kb == '0));

  assert_absent_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bank1_absent |-> (mem_cfg[1:0] == 2'b00 && !error && done));

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(mem_cfg) && $stable(total_kb)));

  assert_quiet_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid);

endmodule

// File: tb/ram_size_probe_tb_top.sv
`timescale 1ns/1ps
module ram_size_probe_tb_top;

  localparam logic [15:0] PAT = 16'hA55A;
  localparam int B1 = 32'h200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mem_req_valid, mem_req_ready, mem_we, mem_rvalid;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic done, error, bank1_absent;
  logic [3:0] mem_cfg;
  logic [12:0] total_kb;

  always #4 clk = ~clk;

  ram_size_probe #(.PATTERN(PAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .error(error), .bank1_absent(bank1_absent),
    .mem_cfg(mem_cfg), .total_kb(total_kb)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model state
  logic [15:0] mem [int];
  int kb0, kb1, corrupt;
  int n_rd, n_wr, n_b1, n_werr, n_outst;
  int first_cfg, first_done;
  bit first_seen;

  function automatic int key_of(input int a);
    int b, off, kb, mask;
    b = (a >= B1) ? 1 : 0;
    off = a - (b ? B1 : 0);
    kb = b ? kb1 : kb0;
    mask = (kb == 128) ? 32'h1FF : (kb == 512) ? 32'h3FF : 32'h1FFFFF;
    return b * 32'h400000 + (off & mask);
  endfunction

  function automatic logic [15:0] rd_model(input int a);
    int kb;
    logic [15:0] v;
    kb = (a >= B1) ? kb1 : kb0;
    if (kb == 0) return 16'h0000;
    v = mem.exists(key_of(a)) ? mem[key_of(a)] : 16'h0000;
    if (a == corrupt) v = ~v;
    return v;
  endfunction

  initial begin
    bit hs, hs_we, rd_act;
    int hs_addr, rd_addr, lat;
    logic [15:0] hs_data;
    hs = 0; rd_act = 0; lat = 0; hs_we = 0; hs_addr = 0; rd_addr = 0; hs_data = '0;
    mem_req_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (hs) begin
        if (hs_we) begin
          int kb;
          kb = (hs_addr >= B1) ? kb1 : kb0;
          if (kb != 0) mem[key_of(hs_addr)] = hs_data;
        end else begin
          rd_act = 1; rd_addr = hs_addr; lat = $urandom_range(0, 2);
        end
      end
      if (rd_act) begin
        if (lat == 0) begin
          mem_rvalid = 1'b1; mem_rdata = rd_model(rd_addr); rd_act = 0;
        end else lat--;
      end
      mem_req_ready = ($urandom_range(0, 3) != 0);
      hs = mem_req_valid && mem_req_ready;
      if (hs) begin
        hs_we = mem_we; hs_addr = int'(mem_addr); hs_data = mem_wdata;
        if (rd_act || mem_rvalid) n_outst++;
        if (!first_seen) begin
          first_seen = 1; first_cfg = int'(mem_cfg); first_done = int'(done);
        end
        if (hs_addr >= B1) n_b1++;
        if (hs_we) begin
          n_wr++;
          if (mem_wdata != (PAT ^ 16'((hs_addr & 32'h1FF) >> 1))) n_werr++;
        end else n_rd++;
      end
    end
  end

  typedef struct {
    int cfg, total, err, absent, reads, writes, b1;
  } exp_t;
  exp_t q[$];
  int seen = 0;

  // monitor: scores each completed probe against the queued expectation
  initial begin
    logic done_d;
    done_d = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && done && !done_d && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(int'(mem_cfg) == e.cfg, "R4 cfg", int'(mem_cfg), e.cfg);
        check(int'(total_kb) == e.total, "R9 total", int'(total_kb), e.total);
        check(int'(error) == e.err, "R7 error", int'(error), e.err);
        check(int'(bank1_absent) == e.absent, "R8 absent", int'(bank1_absent), e.absent);
        check(n_rd == e.reads, "R6 read count", n_rd, e.reads);
        check(n_wr == e.writes, "R3 write count", n_wr, e.writes);
        check(n_werr == 0, "R3 write data", n_werr, 0);
        check(n_outst == 0, "R5 outstanding", n_outst, 0);
        check(first_cfg == 4'hA && first_done == 0, "R2 cfg at first request", first_cfg, 4'hA);
        if (e.b1 == 0) check(n_b1 == 0, "R7 bank1 untouched", n_b1, 0);
        seen++;
      end
      done_d = done;
    end
  end

  task automatic run(input int k0, input int k1, input int corr, input bit extra, input exp_t e);
    int pushed;
    mem.delete();
    kb0 = k0; kb1 = k1; corrupt = corr;
    n_rd = 0; n_wr = 0; n_b1 = 0; n_werr = 0; n_outst = 0; first_seen = 0;
    q.push_back(e);
    pushed = seen + 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra) begin
      repeat (60) @(negedge clk);
      start = 1'b1; // R10: must be ignored mid-probe
      @(negedge clk); start = 1'b0;
    end
    while (seen < pushed) @(negedge clk);
    begin
      int r, w;
      r = n_rd; w = n_wr;
      repeat (6) @(negedge clk);
      check(done == 1'b1 && n_rd == r && n_wr == w, "R11 hold", int'(done), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    kb0 = 0; kb1 = 0; corrupt = -1;
    n_rd = 0; n_wr = 0; n_b1 = 0; n_werr = 0; n_outst = 0; first_seen = 1;
    first_cfg = 0; first_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cfg == 4'h0 && total_kb == 0, "R1 reset cfg/total", int'(mem_cfg), 0);
    check(!done && !error && !bank1_absent && !mem_req_valid, "R1 reset flags",
          int'({done, error, bank1_absent, mem_req_valid}), 0);
    run(128, 128, -1, 0, '{cfg:4'h0, total:256, err:0, absent:0, reads:512, writes:512, b1:1});
    run(512, 2048, -1, 0, '{cfg:4'h6, total:2560, err:0, absent:0, reads:515, writes:512, b1:1});
    run(2048, 0, -1, 0, '{cfg:4'h8, total:2048, err:0, absent:1, reads:261, writes:512, b1:1});
    run(0, 512, -1, 0, '{cfg:4'hA, total:0, err:1, absent:0, reads:3, writes:256, b1:0});
    run(128, 512, 32'h20A, 0, '{cfg:4'h5, total:1024, err:0, absent:0, reads:519, writes:512, b1:1});
    run(2048, 2048, -1, 1, '{cfg:4'hA, total:4096, err:0, absent:0, reads:516, writes:512, b1:1});
    check(q.size() == 0, "R10 no extra result", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule